// File: doc/BRIEF.md
# APB Requester with Wait Watchdog

This block is the requesting side of an APB link with a single subordinate. A client hands it one command at a time on a valid/ready request port: address, direction, write data, byte enables and protection bits. The block turns each command into an APB transfer. The transfer is one SETUP cycle followed by as many ACCESS cycles as the subordinate needs. When the transfer ends, the result goes out on a valid/ready response port as read data and a two-bit status.

The subordinate decides how long a transfer lasts, and the requester cannot force it to finish. To keep a stuck subordinate from hanging the client, a watchdog counts consecutive ACCESS cycles in which PREADY is low. When the count reaches a limit set on a configuration input, the watchdog abandons the transfer. The bus is released on the next cycle, and the response carries a timeout code that is kept separate from a subordinate-reported error. A limit of zero turns the watchdog off.

Only one transfer is in flight at a time. A new command is taken only once the previous response has been accepted, and that acceptance may happen in the same cycle as the new command.

Top module: `apbm_requester`

## Requirements
- R1: A transfer starts with exactly one cycle of psel=1, penable=0, then keeps psel=1, penable=1 until the subordinate raises pready or the watchdog fires.
- R2: paddr, pwrite, pwdata, pstrb and pprot keep the same value from the SETUP cycle through the last ACCESS cycle of a transfer.
- R3: prdata and pslverr are used only in the ACCESS cycle where pready is high. A pslverr pulse during a wait cycle does not change the result. pslverr high at completion gives status 2'b01.
- R4: req_ready is low from the cycle a request is taken until its response has been accepted, so at most one transfer is outstanding. With requests and response acceptance held high, zero-wait transfers complete once every three cycles, and each one has its own SETUP cycle.
- R5: With a nonzero limit L on cfg_wait_limit, after L consecutive ACCESS cycles with pready low, psel and penable are low on the next cycle. The response then carries status 2'b10, and the block goes back to idle and takes new requests.
- R6: A limit of zero disables the watchdog. A transfer then waits for pready for any number of cycles and completes normally.
- R7: On a read request, pstrb is driven to all zeros whatever req_strb holds.
- R8: Status codes are 2'b00 success, 2'b01 subordinate error and 2'b10 timeout. rsp_valid, rsp_status and rsp_rdata stay constant while rsp_ready is low.
- R9: rsp_rdata holds the prdata value from the completion cycle of a read that ends with status 2'b00. For writes, errors and timeouts it is zero.
- R10: After reset, psel, penable and rsp_valid are low and req_ready is high.
- R11: If pready rises in the L-th ACCESS cycle, the transfer completes normally. Completion takes priority over the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wait_limit | input | TW (16) | Maximum number of ACCESS cycles with pready low; 0 disables |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Command taken this cycle if valid |
| req_addr | input | AW (32) | Command address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW (32) | Write data |
| req_strb | input | DW/8 (4) | Byte enables for writes |
| req_prot | input | PW (3) | Protection attributes |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response taken this cycle if valid |
| rsp_status | output | 2 | 00 ok, 01 subordinate error, 10 timeout |
| rsp_rdata | output | DW (32) | Read data |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable (ACCESS phase) |
| paddr | output | AW (32) | APB address |
| pwrite | output | 1 | APB direction |
| pwdata | output | DW (32) | APB write data |
| pstrb | output | DW/8 (4) | APB byte strobes |
| pprot | output | PW (3) | APB protection |
| pready | input | 1 | Subordinate ready |
| prdata | input | DW (32) | Subordinate read data |
| pslverr | input | 1 | Subordinate error |

## Verification
The bench drives garbage on prdata and raises pslverr during wait cycles. A requester that samples these outside the completion cycle would return the wrong data or a false error. It also runs the watchdog at the exact boundary: with a limit of four, pready rises in the fourth ACCESS cycle in one test and never rises in another. An off-by-one counter would either time out a legal transfer or hold the bus for an extra cycle. Other tests stall the response port while a new command waits, to catch a requester that overwrites a pending result or starts a second transfer. A zero limit with a forty-cycle wait catches a watchdog that treats zero as an immediate expiry.

// File: rtl/apbm_pkg.sv
package apbm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'b00,
        PH_SETUP  = 2'b01,
        PH_ACCESS = 2'b10
    } phase_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'b00,
        ST_SLVERR  = 2'b01,
        ST_TIMEOUT = 2'b10
    } status_e;

endpackage

// File: rtl/apbm_watchdog.sv
module apbm_watchdog #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] limit,
    input  logic          active,
    input  logic          stall,
    output logic          expire
);

    typedef struct packed {
        logic [TW-1:0] count;
    } wd_state_t;

    localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

    wd_state_t st_d, st_q;
    logic [TW:0] count_inc;

    always_comb begin
        st_d      = st_q;
        count_inc = {1'b0, st_q.count} + {{TW{1'b0}}, 1'b1};
        expire    = stall && (limit != '0) && (count_inc == {1'b0, limit});
        if (!active) begin
            st_d.count = '0;
        end else if (stall && (st_q.count != CNT_MAX)) begin
            st_d.count = count_inc[TW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_WD_CLEARS_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (st_q.count == '0)) else $error("count kept outside ACCESS"); // R5

    AST_WD_NEEDS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> (active && stall && limit != '0)) else $error("expiry without stall"); // R6

endmodule

// File: rtl/apbm_rsp_slot.sv
module apbm_rsp_slot #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [1:0]    load_status,
    input  logic [DW-1:0] load_rdata,
    input  logic          rsp_ready,
    output logic          rsp_valid,
    output logic [1:0]    rsp_status,
    output logic [DW-1:0] rsp_rdata,
    output logic          slot_free
);

    typedef struct packed {
        logic          valid;
        logic [1:0]    status;
        logic [DW-1:0] rdata;
    } slot_t;

    slot_t sl_d, sl_q;

    always_comb begin
        sl_d = sl_q;
        if (load) begin
            sl_d.valid  = 1'b1;
            sl_d.status = load_status;
            sl_d.rdata  = load_rdata;
        end else if (sl_q.valid && rsp_ready) begin
            sl_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sl_q <= '0;
        else        sl_q <= sl_d;
    end

    assign rsp_valid  = sl_q.valid;
    assign rsp_status = sl_q.status;
    assign rsp_rdata  = sl_q.rdata;
    assign slot_free  = !sl_q.valid || rsp_ready;

    AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) && $stable(rsp_rdata)))
        else $error("response changed under backpressure"); // R8

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!sl_q.valid || rsp_ready)) else $error("pending response overwritten"); // R4

    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_status != 2'b11)) else $error("illegal status code"); // R8

endmodule

// File: rtl/apbm_requester.sv
module apbm_requester #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int PW = 3,
    parameter int TW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TW-1:0]     cfg_wait_limit,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_addr,
    input  logic              req_write,
    input  logic [DW-1:0]     req_wdata,
    input  logic [DW/8-1:0]   req_strb,
    input  logic [PW-1:0]     req_prot,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [1:0]        rsp_status,
    output logic [DW-1:0]     rsp_rdata,
    output logic              psel,
    output logic              penable,
    output logic [AW-1:0]     paddr,
    output logic              pwrite,
    output logic [DW-1:0]     pwdata,
    output logic [DW/8-1:0]   pstrb,
    output logic [PW-1:0]     pprot,
    input  logic              pready,
    input  logic [DW-1:0]     prdata,
    input  logic              pslverr
);
    import apbm_pkg::*;

    localparam int SW = DW / 8;

    typedef struct packed {
        phase_e        phase;
        logic [AW-1:0] addr;
        logic          write;
        logic [DW-1:0] wdata;
        logic [SW-1:0] strb;
        logic [PW-1:0] prot;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic          slot_free;
    logic          wd_expire;
    logic          in_access;
    logic          wait_cycle;
    logic          finish_ok;
    logic          finish;
    logic          take_req;
    logic [1:0]    fin_status;
    logic [DW-1:0] fin_rdata;

    assign in_access  = (ctl_q.phase == PH_ACCESS);
    assign wait_cycle = in_access && !pready;
    assign finish_ok  = in_access && pready;
    assign finish     = finish_ok || wd_expire;
    assign req_ready  = (ctl_q.phase == PH_IDLE) && slot_free;
    assign take_req   = req_valid && req_ready;

    always_comb begin
        ctl_d      = ctl_q;
        fin_status = ST_TIMEOUT;
        fin_rdata  = '0;
        if (finish_ok) begin
            fin_status = pslverr ? ST_SLVERR : ST_OK;
            if (!ctl_q.write && !pslverr) fin_rdata = prdata;
        end
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (take_req) begin
                    ctl_d.phase = PH_SETUP;
                    ctl_d.addr  = req_addr;
                    ctl_d.write = req_write;
                    ctl_d.wdata = req_write ? req_wdata : '0;
                    ctl_d.strb  = req_write ? req_strb : '0;
                    ctl_d.prot  = req_prot;
                end
            end
            PH_SETUP: begin
                ctl_d.phase = PH_ACCESS;
            end
            PH_ACCESS: begin
                if (finish) ctl_d.phase = PH_IDLE;
            end
            default: begin
                ctl_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.phase <= PH_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign psel    = (ctl_q.phase != PH_IDLE);
    assign penable = in_access;
    assign paddr   = ctl_q.addr;
    assign pwrite  = ctl_q.write;
    assign pwdata  = ctl_q.wdata;
    assign pstrb   = ctl_q.strb;
    assign pprot   = ctl_q.prot;

    apbm_watchdog #(.TW(TW)) u_watchdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .limit  (cfg_wait_limit),
        .active (in_access),
        .stall  (wait_cycle),
        .expire (wd_expire)
    );

    apbm_rsp_slot #(.DW(DW)) u_rsp_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (finish),
        .load_status (fin_status),
        .load_rdata  (fin_rdata),
        .rsp_ready   (rsp_ready),
        .rsp_valid   (rsp_valid),
        .rsp_status  (rsp_status),
        .rsp_rdata   (rsp_rdata),
        .slot_free   (slot_free)
    );

    AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(penable) |-> $past(psel && !penable)) else $error("ACCESS without SETUP"); // R1

    AST_SETUP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable) |=> (psel && penable)) else $error("SETUP not followed by ACCESS"); // R1

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pready && !wd_expire) |=> (psel && penable && !rsp_valid))
        else $error("transfer ended without pready"); // R3

    AST_FROZEN_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable) |-> ($stable(paddr) && $stable(pwrite) && $stable(pwdata)
                               && $stable(pstrb) && $stable(pprot)))
        else $error("transfer attributes moved"); // R2

    AST_READ_NO_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite) |-> (pstrb == '0)) else $error("strobes on read"); // R7

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> !psel) else $error("request taken mid-transfer"); // R4

    AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |=> (!psel && !penable && rsp_valid && rsp_status == 2'b10))
        else $error("timeout did not release bus"); // R5

    AST_READY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pready) |=> (rsp_valid && rsp_status != 2'b10))
        else $error("completion reported as timeout"); // R11

endmodule

// File: tb/apbm_requester_bench.sv
module apbm_requester_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_wait_limit = 16'd8;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_strb = '0;
    logic [2:0]  req_prot = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_rdata;
    logic        psel, penable, pwrite;
    logic [31:0] paddr, pwdata;
    logic [3:0]  pstrb;
    logic [2:0]  pprot;
    logic        pready, pslverr;
    logic [31:0] prdata;

    always #2 clk = ~clk;

    apbm_requester u_apbm_requester (
        .clk(clk), .rst_n(rst_n), .cfg_wait_limit(cfg_wait_limit),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata), .req_strb(req_strb),
        .req_prot(req_prot), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_status(rsp_status), .rsp_rdata(rsp_rdata), .psel(psel),
        .penable(penable), .paddr(paddr), .pwrite(pwrite), .pwdata(pwdata),
        .pstrb(pstrb), .pprot(pprot), .pready(pready), .prdata(prdata),
        .pslverr(pslverr)
    );

    // subordinate model: wait_n < 0 means never ready
    int          wait_n = 0;
    int          acc_n = 0;
    logic        sub_err = 1'b0;
    logic        sub_err_wait = 1'b0;
    logic [31:0] sub_rdata = '0;

    assign pready  = psel && penable && (wait_n >= 0) && (acc_n == wait_n);
    assign pslverr = psel && penable && (pready ? sub_err : sub_err_wait);
    assign prdata  = pready ? sub_rdata : 32'hDEAD_BEEF;

    always @(posedge clk) begin
        if (psel && !penable)               acc_n <= 0;
        else if (psel && penable && !pready) acc_n <= acc_n + 1;
    end

    // bus monitor, sampled mid-cycle
    int          cyc = 0, mon_acc = 0, stab_err = 0, rd_strb_err = 0, setup_cnt = 0;
    int          last_comp = 0, prev_comp = 0;
    logic [31:0] s_addr, s_wdata;
    logic        s_write;
    logic [3:0]  s_strb;
    logic [2:0]  s_prot;

    always @(negedge clk) begin
        cyc++;
        if (psel && !penable) begin
            setup_cnt++;
            mon_acc = 0;
            s_addr = paddr; s_wdata = pwdata; s_write = pwrite; s_strb = pstrb; s_prot = pprot;
        end else if (psel && penable) begin
            mon_acc++;
            if (paddr != s_addr || pwdata != s_wdata || pwrite != s_write
                || pstrb != s_strb || pprot != s_prot) stab_err++;
            if (pready) begin prev_comp = last_comp; last_comp = cyc; end
        end
        if (psel && !pwrite && pstrb != 4'h0) rd_strb_err++;
    end

    int tests = 0, fails = 0;
    logic done = 1'b0;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] a, input logic w, input logic [31:0] d,
                         input logic [3:0] s, input logic [2:0] p);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = d; req_strb = s; req_prot = p;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic collect(output logic [1:0] st, output logic [31:0] rd, output logic bus_on);
        while (!rsp_valid) @(negedge clk);
        st = rsp_status; rd = rsp_rdata; bus_on = psel;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R10", "psel", psel, 0);
        chk("R10", "penable", penable, 0);
        chk("R10", "rsp_valid", rsp_valid, 0);
        chk("R10", "req_ready", req_ready, 1);
    endtask

    task automatic t_write_basic;
        logic [1:0] st; logic [31:0] rd; logic b; int s0;
        cfg_wait_limit = 16'd8; wait_n = 0; sub_err = 0; sub_err_wait = 0;
        s0 = setup_cnt;
        issue(32'h0000_0100, 1'b1, 32'h1234_5678, 4'b0101, 3'b010);
        collect(st, rd, b);
        chk("R8", "write status", st, 2'b00);
        chk("R9", "write rdata zero", rd, 0);
        chk("R1", "one SETUP", setup_cnt - s0, 1);
        chk("R1", "access cycles", mon_acc, 1);
        chk("R2", "strobe driven", s_strb, 4'b0101);
        chk("R2", "prot driven", s_prot, 3'b010);
        chk("R2", "stability", stab_err, 0);
    endtask

    task automatic t_read_waits;
        logic [1:0] st; logic [31:0] rd; logic b;
        wait_n = 3; sub_rdata = 32'hA5A5_0F0F;
        issue(32'h0000_0204, 1'b0, 32'hFFFF_FFFF, 4'hF, 3'b001);
        collect(st, rd, b);
        chk("R9", "read data", rd, 32'hA5A5_0F0F);
        chk("R3", "status", st, 2'b00);
        chk("R1", "access cycles with 3 waits", mon_acc, 4);
        chk("R7", "read strobes zero", rd_strb_err, 0);
        chk("R2", "stability with waits", stab_err, 0);
    endtask

    task automatic t_read_err;
        logic [1:0] st; logic [31:0] rd; logic b;
        wait_n = 1; sub_err = 1; sub_rdata = 32'h7777_7777;
        issue(32'h0000_0300, 1'b0, 0, 4'h0, 3'b000);
        collect(st, rd, b);
        sub_err = 0;
        chk("R3", "slverr status", st, 2'b01);
        chk("R9", "error rdata zero", rd, 0);
    endtask

    task automatic t_err_in_wait;
        logic [1:0] st; logic [31:0] rd; logic b;
        wait_n = 2; sub_err_wait = 1; sub_rdata = 32'h0BAD_CAFE;
        issue(32'h0000_0304, 1'b0, 0, 4'h0, 3'b000);
        collect(st, rd, b);
        sub_err_wait = 0;
        chk("R3", "wait-cycle pslverr ignored", st, 2'b00);
        chk("R3", "data from completion cycle", rd, 32'h0BAD_CAFE);
    endtask

    task automatic t_timeout;
        logic [1:0] st; logic [31:0] rd; logic b;
        cfg_wait_limit = 16'd4; wait_n = -1;
        issue(32'h0000_0400, 1'b0, 0, 4'h0, 3'b000);
        collect(st, rd, b);
        chk("R5", "timeout status", st, 2'b10);
        chk("R5", "access cycles before abort", mon_acc, 4);
        chk("R5", "bus released", b, 0);
        chk("R9", "timeout rdata zero", rd, 0);
        wait_n = 0;
        issue(32'h0000_0404, 1'b1, 32'h55, 4'h1, 3'b000);
        collect(st, rd, b);
        chk("R5", "next transfer after timeout", st, 2'b00);
    endtask

    task automatic t_limit_edge;
        logic [1:0] st; logic [31:0] rd; logic b;
        cfg_wait_limit = 16'd4; wait_n = 3; sub_rdata = 32'h0000_0444;
        issue(32'h0000_0500, 1'b0, 0, 4'h0, 3'b000);
        collect(st, rd, b);
        chk("R11", "ready on last cycle wins", st, 2'b00);
        chk("R11", "access cycles", mon_acc, 4);
        chk("R11", "data", rd, 32'h0000_0444);
    endtask

    task automatic t_limit_zero;
        logic [1:0] st; logic [31:0] rd; logic b;
        cfg_wait_limit = 16'd0; wait_n = 40;
        issue(32'h0000_0600, 1'b1, 32'h9, 4'hF, 3'b000);
        collect(st, rd, b);
        chk("R6", "disabled watchdog completes", st, 2'b00);
        chk("R6", "access cycles", mon_acc, 41);
        cfg_wait_limit = 16'd8;
    endtask

    task automatic t_backpressure;
        logic [1:0] st0; logic [31:0] rd0; int s0; logic bad;
        logic [1:0] st; logic [31:0] rd; logic b;
        wait_n = 1; sub_rdata = 32'hCAFE_0001;
        issue(32'h0000_0700, 1'b0, 0, 4'h0, 3'b000);
        while (!rsp_valid) @(negedge clk);
        st0 = rsp_status; rd0 = rsp_rdata; s0 = setup_cnt;
        req_valid = 1'b1; req_addr = 32'h0000_0704; req_write = 1'b1; req_wdata = 32'h22; req_strb = 4'h3;
        bad = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (!rsp_valid || rsp_status != st0 || rsp_rdata != rd0) bad = 1'b1;
            if (req_ready) bad = 1'b1;
        end
        chk("R8", "response held under backpressure", bad, 0);
        chk("R4", "no new transfer while response pending", setup_cnt - s0, 0);
        chk("R8", "held data", rd0, 32'hCAFE_0001);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b0;
        collect(st, rd, b);
        chk("R4", "queued request ran after accept", setup_cnt - s0, 1);
        chk("R4", "queued status", st, 2'b00);
    endtask

    task automatic t_stream;
        int accepted, got, s0;
        wait_n = 0; s0 = setup_cnt; accepted = 0; got = 0;
        @(negedge clk);
        rsp_ready = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h0000_0800; req_strb = 4'hF;
        for (int i = 0; i < 60 && got < 3; i++) begin
            if (req_valid && req_ready) accepted++;
            if (rsp_valid) got++;
            @(negedge clk);
            if (accepted >= 3) req_valid = 1'b0;
            req_addr = 32'h0000_0800 + 32'(accepted * 4);
        end
        rsp_ready = 1'b0; req_valid = 1'b0;
        chk("R4", "three responses", got, 3);
        chk("R4", "each with SETUP", setup_cnt - s0, 3);
        chk("R4", "completion spacing", last_comp - prev_comp, 3);
        chk("R2", "stream stability", stab_err, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_basic();
        t_read_waits();
        t_read_err();
        t_err_in_wait();
        t_timeout();
        t_limit_edge();
        t_limit_zero();
        t_backpressure();
        t_stream();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule